// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to a usable state. After reset it holds the command pins at NOP and waits for the power-up delay. Partway through that wait it raises the clock enable. Once the delay has run out, it closes every bank with a precharge-all. It then issues two auto-refresh commands and programs the mode register. The required recovery gap follows each command, and NOPs fill every gap. When the last gap has elapsed it raises a done flag that stays high, and the memory controller may then take over the command bus.

Every wait is a parameter counted in clock cycles. The power-up delay is the clock frequency in MHz multiplied by the delay in microseconds. The mode word is assembled from named fields: burst length, burst type, CAS latency and write-burst policy. The command pins are registered straight out of a ten-state sequencer, so every command lands on a predictable clock.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, the command is NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), clock enable is low, bank and address are zero and the done flag is low.
- R2: Let P = CLK_FREQ_MHZ*POWERUP_US, and let cycle t be the cycle after the t-th rising edge following reset release, with t=0 being the cycle right after release. During cycles 0 to P-1 the command is NOP.
- R3: Clock enable is low up to cycle P-CKE_LEAD_CYC-1. It is high from cycle P-CKE_LEAD_CYC onwards and never falls again. No command other than NOP is issued while it is low.
- R4: At cycle P the command is PRECHARGE (4'b0010) with address bit 10 high and all other address bits zero, which closes all banks.
- R5: The first AUTO REFRESH (4'b0001) appears at cycle P+T_RP, with NOP in the cycles in between.
- R6: The second AUTO REFRESH appears at cycle P+T_RP+T_RFC, with NOP in the cycles in between.
- R7: LOAD MODE (4'b0000) appears at cycle P+T_RP+2*T_RFC, with NOP in the cycles in between. Both bank address bits are zero in every cycle.
- R8: During LOAD MODE the address carries the mode word: bits 2:0 burst length code (1→000, 2→001, 4→010, 8→011, full page (BURST_LEN=0)→111), bit 3 burst type (1 interleaved), bits 6:4 CAS latency (2→010, 3→011), bits 8:7 zero, bit 9 single-location writes, bits 12:10 zero. The default configuration gives 13'h027.
- R9: The done flag rises at cycle P+T_RP+2*T_RFC+T_MRD and stays high. The command is NOP in every cycle other than the four command cycles, and the address is zero outside those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus (A10 for precharge-all, mode word for LOAD MODE) |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Every output is one register stage after the sequencer state, so the value for cycle t is visible in the half-period after the t-th rising edge following reset release. The bench counts edges from release and samples each negative edge. At each sample it compares command, clock enable, bank, address and done against a behavioural model that holds only the four command cycle numbers, the clock-enable rise cycle and the done cycle, computed from the parameters. Two instances with different delays, gaps and mode fields are checked side by side. A command arriving one cycle early or late therefore shows up as a mismatch on that exact cycle.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_PRECH,
        ST_WAIT_RP,
        ST_REF1,
        ST_WAIT_RFC1,
        ST_REF2,
        ST_WAIT_RFC2,
        ST_LMR,
        ST_WAIT_MRD,
        ST_DONE
    } boot_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP   = sd_cmd_t'(4'b0111);
    localparam sd_cmd_t CMD_PRECH = sd_cmd_t'(4'b0010);
    localparam sd_cmd_t CMD_REF   = sd_cmd_t'(4'b0001);
    localparam sd_cmd_t CMD_LMR   = sd_cmd_t'(4'b0000);

    // Burst length field code; 0 selects full page.
    function automatic logic [2:0] bl_code(input int len);
        case (len)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    // CAS latency field code; anything but 3 selects 2.
    function automatic logic [2:0] cl_code(input int lat);
        return (lat == 3) ? 3'b011 : 3'b010;
    endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(RESET_VAL);
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    // Without a reload the count saturates at zero (wait windows of R2, R5-R7)
    assert_timer_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

    // Each step either reloads or moves down by one (wait windows of R2)
    assert_timer_steps_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - 1'b1));

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
    import sdram_boot_pkg::*;
#(
    parameter int ADDR_W           = 13,
    parameter int BURST_LEN        = 0,
    parameter int BURST_INTERLEAVE = 0,
    parameter int CAS_LATENCY      = 2,
    parameter int SINGLE_WRITE     = 0
) (
    output logic [ADDR_W-1:0] mode_o
);

    localparam logic [2:0] BL_FIELD = bl_code(BURST_LEN);
    localparam logic [2:0] CL_FIELD = cl_code(CAS_LATENCY);
    localparam logic       BT_FIELD = (BURST_INTERLEAVE != 0);
    localparam logic       WB_FIELD = (SINGLE_WRITE != 0);

    logic [12:0] core_word;

    always_comb begin
        core_word        = '0;
        core_word[2:0]   = BL_FIELD;
        core_word[3]     = BT_FIELD;
        core_word[6:4]   = CL_FIELD;
        core_word[8:7]   = 2'b00;
        core_word[9]     = WB_FIELD;
        core_word[12:10] = 3'b000;
    end

    generate
        if (ADDR_W > 13) begin : g_wide
            assign mode_o = {{(ADDR_W-13){1'b0}}, core_word};
        end else begin : g_exact
            assign mode_o = core_word[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
    import sdram_boot_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  boot_state_e       state_i,
    input  logic [ADDR_W-1:0] mode_i,
    output sd_cmd_t           cmd_o,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        cmd_o  = CMD_NOP;
        addr_o = '0;
        case (state_i)
            ST_PRECH: begin
                cmd_o      = CMD_PRECH;
                addr_o[10] = 1'b1;
            end
            ST_REF1, ST_REF2: cmd_o = CMD_REF;
            ST_LMR: begin
                cmd_o  = CMD_LMR;
                addr_o = mode_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CLK_FREQ_MHZ     = 125,
    parameter int POWERUP_US       = 200,
    parameter int T_RP             = 2,
    parameter int T_RFC            = 7,
    parameter int T_MRD            = 3,
    parameter int CKE_LEAD_CYC     = 16,
    parameter int BURST_LEN        = 0,
    parameter int BURST_INTERLEAVE = 0,
    parameter int CAS_LATENCY      = 2,
    parameter int SINGLE_WRITE     = 0,
    parameter int ADDR_W           = 13,
    parameter int BANK_W           = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    localparam int PWR_RAW  = CLK_FREQ_MHZ * POWERUP_US;
    localparam int PWR_CYC  = (PWR_RAW < 2) ? 2 : PWR_RAW;
    localparam int RP_GAP   = (T_RP  < 2) ? 2 : T_RP;
    localparam int RFC_GAP  = (T_RFC < 2) ? 2 : T_RFC;
    localparam int MRD_GAP  = (T_MRD < 2) ? 2 : T_MRD;
    localparam int CKE_LEAD = (CKE_LEAD_CYC > PWR_CYC - 1) ? PWR_CYC - 1 : CKE_LEAD_CYC;
    localparam int CNT_W    = $clog2(PWR_CYC) + 1;

    typedef struct packed {
        boot_state_e       state;
        sd_cmd_t           cmd;
        logic              cke;
        logic              done;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    boot_state_e       nxt_state;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_zero;
    logic [ADDR_W-1:0] mode_word;
    sd_cmd_t           enc_cmd;
    logic [ADDR_W-1:0] enc_addr;

    sdram_boot_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (PWR_CYC - 1)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .cnt_o      (tmr_cnt),
        .zero_o     (tmr_zero)
    );

    sdram_mode_word #(
        .ADDR_W           (ADDR_W),
        .BURST_LEN        (BURST_LEN),
        .BURST_INTERLEAVE (BURST_INTERLEAVE),
        .CAS_LATENCY      (CAS_LATENCY),
        .SINGLE_WRITE     (SINGLE_WRITE)
    ) u_mode (
        .mode_o (mode_word)
    );

    sdram_cmd_encode #(
        .ADDR_W (ADDR_W)
    ) u_enc (
        .state_i (nxt_state),
        .mode_i  (mode_word),
        .cmd_o   (enc_cmd),
        .addr_o  (enc_addr)
    );

    // Sequencer: a command state lasts one cycle and loads the gap timer,
    // and the following wait state leaves when the timer reads zero.
    always_comb begin
        nxt_state = r_q.state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (r_q.state)
            ST_POWERUP:   if (tmr_zero) nxt_state = ST_PRECH;
            ST_PRECH: begin
                nxt_state = ST_WAIT_RP;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(RP_GAP - 2);
            end
            ST_WAIT_RP:   if (tmr_zero) nxt_state = ST_REF1;
            ST_REF1: begin
                nxt_state = ST_WAIT_RFC1;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(RFC_GAP - 2);
            end
            ST_WAIT_RFC1: if (tmr_zero) nxt_state = ST_REF2;
            ST_REF2: begin
                nxt_state = ST_WAIT_RFC2;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(RFC_GAP - 2);
            end
            ST_WAIT_RFC2: if (tmr_zero) nxt_state = ST_LMR;
            ST_LMR: begin
                nxt_state = ST_WAIT_MRD;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(MRD_GAP - 2);
            end
            ST_WAIT_MRD:  if (tmr_zero) nxt_state = ST_DONE;
            default:      nxt_state = ST_DONE;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.state = nxt_state;
        r_d.cmd   = enc_cmd;
        r_d.addr  = enc_addr;
        r_d.ba    = '0;
        r_d.cke   = r_q.cke || (r_q.state != ST_POWERUP) ||
                    (tmr_cnt <= CNT_W'(CKE_LEAD));
        r_d.done  = (nxt_state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_POWERUP;
            r_q.cmd   <= CMD_NOP;
            r_q.cke   <= 1'b0;
            r_q.done  <= 1'b0;
            r_q.ba    <= '0;
            r_q.addr  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sd_cke    = r_q.cke;
    assign sd_cs_n   = r_q.cmd.cs_n;
    assign sd_ras_n  = r_q.cmd.ras_n;
    assign sd_cas_n  = r_q.cmd.cas_n;
    assign sd_we_n   = r_q.cmd.we_n;
    assign sd_ba     = r_q.ba;
    assign sd_addr   = r_q.addr;
    assign init_done = r_q.done;

    sd_cmd_t pin_cmd;
    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    assert_cmd_needs_cke_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != CMD_NOP) |-> sd_cke);

    assert_cke_stays_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);

    assert_prech_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_PRECH) |-> sd_addr[10]);

    assert_lmr_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_LMR) |-> (sd_ba == '0 && sd_addr == mode_word));

    assert_nop_after_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != CMD_NOP) |=> (pin_cmd == CMD_NOP));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pin_cmd == CMD_NOP && sd_cke));

endmodule

// File: tb/sdram_boot_seq_bench.sv
module sdram_boot_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    // Instance A: P=500, gaps 2/7/3, lead 16, default mode word
    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba;
    logic [12:0] a_addr;
    // Instance B: P=125, gaps 3/5/2, lead 4, BL4 interleaved CL3 single write
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba;
    logic [12:0] b_addr;

    sdram_boot_seq #(
        .CLK_FREQ_MHZ (125),
        .POWERUP_US   (4)
    ) u_sdram_boot_seq (
        .clk (clk), .rst_n (rst_n), .sd_cke (a_cke), .sd_cs_n (a_cs),
        .sd_ras_n (a_ras), .sd_cas_n (a_cas), .sd_we_n (a_we),
        .sd_ba (a_ba), .sd_addr (a_addr), .init_done (a_done)
    );

    sdram_boot_seq #(
        .CLK_FREQ_MHZ     (125),
        .POWERUP_US       (1),
        .T_RP             (3),
        .T_RFC            (5),
        .T_MRD            (2),
        .CKE_LEAD_CYC     (4),
        .BURST_LEN        (4),
        .BURST_INTERLEAVE (1),
        .CAS_LATENCY      (3),
        .SINGLE_WRITE     (1)
    ) u_sdram_boot_seq_alt (
        .clk (clk), .rst_n (rst_n), .sd_cke (b_cke), .sd_cs_n (b_cs),
        .sd_ras_n (b_ras), .sd_cas_n (b_cas), .sd_we_n (b_we),
        .sd_ba (b_ba), .sd_addr (b_addr), .init_done (b_done)
    );

    task automatic compare(input string nm, input string tag, input string what,
                           input int t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s %s cycle %0d: actual=%0h expected=%0h",
                     tag, nm, what, t, act, exp);
        end
    endtask

    // Behavioural reference: the command schedule as plain cycle numbers
    task automatic check_inst(input string nm, input int t, input bit in_reset,
                              input int p, input int rp, input int rfc, input int mrd,
                              input int lead, input logic [12:0] mode,
                              input logic [3:0] cmd, input logic cke,
                              input logic [1:0] ba, input logic [12:0] addr,
                              input logic done);
        int    c_pre, c_ref1, c_ref2, c_lmr, c_done;
        int    e_cmd, e_addr;
        string tag, atag;
        c_pre  = p;
        c_ref1 = c_pre + rp;
        c_ref2 = c_ref1 + rfc;
        c_lmr  = c_ref2 + rfc;
        c_done = c_lmr + mrd;
        if (in_reset) begin
            compare(nm, "R1", "cmd",  t, cmd,  4'b0111);
            compare(nm, "R1", "cke",  t, cke,  0);
            compare(nm, "R1", "ba",   t, ba,   0);
            compare(nm, "R1", "addr", t, addr, 0);
            compare(nm, "R1", "done", t, done, 0);
            return;
        end
        e_cmd = 4'b0111; e_addr = 0; tag = "R9";
        if (t < c_pre)        tag = "R2";
        else if (t == c_pre)  begin e_cmd = 4'b0010; e_addr = 13'h0400; tag = "R4"; end
        else if (t == c_ref1) begin e_cmd = 4'b0001; tag = "R5"; end
        else if (t == c_ref2) begin e_cmd = 4'b0001; tag = "R6"; end
        else if (t == c_lmr)  begin e_cmd = 4'b0000; e_addr = mode; tag = "R7"; end
        else if (t < c_ref1)  tag = "R5";
        else if (t < c_ref2)  tag = "R6";
        else if (t < c_lmr)   tag = "R7";
        atag = (t == c_lmr) ? "R8" : tag;
        compare(nm, tag,  "cmd",  t, cmd,  e_cmd);
        compare(nm, atag, "addr", t, addr, e_addr);
        compare(nm, "R7", "ba",   t, ba,   0);
        compare(nm, "R3", "cke",  t, cke,  (t >= p - lead) ? 1 : 0);
        compare(nm, "R9", "done", t, done, (t >= c_done) ? 1 : 0);
    endtask

    task automatic check_both(input int t, input bit in_reset);
        check_inst("A", t, in_reset, 500, 2, 7, 3, 16, 13'h027,
                   {a_cs, a_ras, a_cas, a_we}, a_cke, a_ba, a_addr, a_done);
        check_inst("B", t, in_reset, 125, 3, 5, 2, 4, 13'h23A,
                   {b_cs, b_ras, b_cas, b_we}, b_cke, b_ba, b_addr, b_done);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_both(0, 1'b1);          // R1 reset state
        rst_n = 1'b1;
        for (int t = 0; t <= 545; t++) begin
            check_both(t, 1'b0);
            @(posedge clk);
            @(negedge clk);
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 5000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule